// File: doc/BRIEF.md
# Deferred Invalidation Queue with Load Barrier

This block sits beside a core's private cache and takes Invalidate messages sent by other cores. It stores the address of each message in a small ordered queue and answers with an acknowledge on the next cycle. The local cache lines are left as they are, so the sender does not have to wait for the local state change. Until the deferred work is done, local loads may still hit the old copy of a line.

A load barrier request makes the block drain the queue. It removes one entry per cycle, oldest first, and writes the Invalid state for that entry's line through the state write port. Messages that arrive during the drain are also drained before the barrier reports completion. The block keeps one valid bit per line. A fill port sets that bit, and a load lookup port reports whether a load must go out as a read request or may use the cached copy.

Top module: `invQueueBarrier`

## Requirements
- R1: After reset the queue is empty, `invReady` is 1, `ackValid`, `barrierDone` and `stateWrEn` are 0, and every line is invalid, so `loadReadReq` equals `loadValid`.
- R2: An Invalidate accepted at a clock edge (`invValid` and `invReady` both 1) gives `ackValid`=1 with `ackAddr` equal to its address during the following cycle. The line's valid bit does not change, so a load to it still reports no read request.
- R3: The queue holds 4 distinct addresses. With 4 queued, `invReady` is 0, and an Invalidate offered then is neither stored nor acknowledged.
- R4: An Invalidate whose address is already queued is acknowledged but not stored a second time. An address in the head entry that is being drained in the same cycle does not count as already queued.
- R5: After a barrier request, starting the cycle after `barrierReq` is seen while idle, the block drains one entry per cycle in arrival order. Each drained entry gives `stateWrEn`=1 and `stateWrAddr` equal to its address in that cycle.
- R6: When the draining queue is empty and nothing is enqueued in that cycle, `barrierDone` pulses for one cycle in the next cycle. A barrier on an empty queue signals done two cycles after the request.
- R7: `loadReadReq` is combinational and equals `loadValid` AND NOT the line valid bit of `loadAddr`. From the cycle after a line's state write, a load to that line reports a read request.
- R8: Invalidates accepted while a barrier is draining are enqueued and drained before that barrier's `barrierDone`.
- R9: `fillValid` sets the valid bit of `fillAddr` at the clock edge. If a state write targets the same line at the same edge, the line ends up invalid.
- R10: `barrierReq` is ignored while a drain is in progress, and it produces no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| invValid | input | 1 | Incoming Invalidate message present |
| invAddr | input | 4 | Line address of the Invalidate |
| invReady | output | 1 | Queue can take a message |
| ackValid | output | 1 | Invalidate acknowledge |
| ackAddr | output | 4 | Address being acknowledged |
| barrierReq | input | 1 | Load barrier request |
| barrierDone | output | 1 | Barrier finished, one-cycle pulse |
| stateWrEn | output | 1 | Cache state write to Invalid |
| stateWrAddr | output | 4 | Line written to Invalid |
| fillValid | input | 1 | Line filled, mark valid |
| fillAddr | input | 4 | Filled line address |
| loadValid | input | 1 | Load lookup request |
| loadAddr | input | 4 | Load line address |
| loadReadReq | output | 1 | Load must issue a read request |

## Verification
The acknowledge is due one cycle after the accepting edge. A state write appears in the same cycle its entry is popped, and pops begin one cycle after the barrier request. Done comes one cycle after the first empty drain cycle, and load lookups answer in the cycle they are asked, using the line bits as of the last edge. The bench's reference model takes one step per clock at the falling edge. It first compares every output against what its own state predicts for the current inputs, and then advances that state as the coming rising edge will. Because of this, each result is checked in exactly the cycle it is due.

// File: rtl/iqPkg.sv
package iqPkg;
  // strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic push;   // store the incoming address as a new entry
    logic pop;    // retire the head entry and invalidate its line
  } iqStrobes_t;
endpackage

// File: rtl/iqDatapath.sv
module iqDatapath
  import iqPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  iqStrobes_t        strb,
  input  logic [ADDR_W-1:0] invAddr,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [ADDR_W-1:0] loadAddr,
  output logic              full,
  output logic              empty,
  output logic              dupHit,
  output logic [ADDR_W-1:0] headAddr,
  output logic              loadLineValid
);
  localparam int LINES = 1 << ADDR_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] entryAddr [DEPTH];
  logic [DEPTH-1:0]  entryVld;
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count;
  logic [DEPTH-1:0]  matchVec, popMask;
  logic [LINES-1:0]  lineValid;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign headAddr = entryAddr[rdPtr];
  assign popMask  = strb.pop ? (DEPTH'(1) << rdPtr) : '0;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_match
      assign matchVec[i] = entryVld[i] && (entryAddr[i] == invAddr);
    end
  endgenerate

  // the entry retiring this cycle no longer covers a new arrival
  assign dupHit        = |(matchVec & ~popMask);
  assign loadLineValid = lineValid[loadAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      count    <= '0;
      entryVld <= '0;
      for (int i = 0; i < DEPTH; i++) entryAddr[i] <= '0;
    end else begin
      if (strb.pop) begin
        entryVld[rdPtr] <= 1'b0;
        rdPtr           <= nextPtr(rdPtr);
      end
      if (strb.push) begin
        entryAddr[wrPtr] <= invAddr;
        entryVld[wrPtr]  <= 1'b1;
        wrPtr            <= nextPtr(wrPtr);
      end
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // line state: invalidation beats a fill at the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineValid <= '0;
    end else begin
      if (fillValid) lineValid[fillAddr] <= 1'b1;
      if (strb.pop)  lineValid[headAddr] <= 1'b0;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !full);

  p_unique_entries_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  p_line_cleared_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> !lineValid[$past(headAddr)]);
endmodule

// File: rtl/iqControl.sv
module iqControl
  import iqPkg::*;
#(
  parameter int ADDR_W = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              invValid,
  input  logic [ADDR_W-1:0] invAddr,
  input  logic              barrierReq,
  input  logic              full,
  input  logic              empty,
  input  logic              dupHit,
  output iqStrobes_t        strb,
  output logic              invReady,
  output logic              ackValid,
  output logic [ADDR_W-1:0] ackAddr,
  output logic              barrierDone
);
  logic draining;
  logic accept;
  logic finish;

  assign invReady  = !full;
  assign accept    = invValid && invReady;
  assign strb.push = accept && !dupHit;
  assign strb.pop  = draining && !empty;
  assign finish    = draining && empty && !strb.push;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid    <= 1'b0;
      ackAddr     <= '0;
      draining    <= 1'b0;
      barrierDone <= 1'b0;
    end else begin
      ackValid    <= accept;
      ackAddr     <= invAddr;
      barrierDone <= finish;
      if (finish)                       draining <= 1'b0;
      else if (!draining && barrierReq) draining <= 1'b1;
    end
  end

  p_done_ends_drain_r6: assert property (@(posedge clk) disable iff (!rstN)
    barrierDone |-> (!draining && $past(draining)));

  p_req_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (draining && !finish) |=> draining);
endmodule

// File: rtl/invQueueBarrier.sv
module invQueueBarrier
  import iqPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              invValid,
  input  logic [ADDR_W-1:0] invAddr,
  output logic              invReady,
  output logic              ackValid,
  output logic [ADDR_W-1:0] ackAddr,
  input  logic              barrierReq,
  output logic              barrierDone,
  output logic              stateWrEn,
  output logic [ADDR_W-1:0] stateWrAddr,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic              loadValid,
  input  logic [ADDR_W-1:0] loadAddr,
  output logic              loadReadReq
);
  iqStrobes_t        strb;
  logic              full, empty, dupHit, loadLineValid;
  logic [ADDR_W-1:0] headAddr;

  iqControl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .invValid(invValid), .invAddr(invAddr),
    .barrierReq(barrierReq), .full(full), .empty(empty), .dupHit(dupHit),
    .strb(strb), .invReady(invReady), .ackValid(ackValid), .ackAddr(ackAddr),
    .barrierDone(barrierDone)
  );

  iqDatapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .invAddr(invAddr),
    .fillValid(fillValid), .fillAddr(fillAddr), .loadAddr(loadAddr),
    .full(full), .empty(empty), .dupHit(dupHit), .headAddr(headAddr),
    .loadLineValid(loadLineValid)
  );

  assign stateWrEn   = strb.pop;
  assign stateWrAddr = headAddr;
  assign loadReadReq = loadValid && !loadLineValid;

  p_done_queue_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    barrierDone |-> empty);

  p_ack_after_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(invReady));
endmodule

// File: tb/tb_invQueueBarrier.sv
module tb_invQueueBarrier;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       invValid = 1'b0, barrierReq = 1'b0, fillValid = 1'b0, loadValid = 1'b0;
  logic [3:0] invAddr = '0, fillAddr = '0, loadAddr = '0;
  logic       invReady, ackValid, barrierDone, stateWrEn, loadReadReq;
  logic [3:0] ackAddr, stateWrAddr;

  invQueueBarrier dut (
    .clk(clk), .rstN(rstN), .invValid(invValid), .invAddr(invAddr),
    .invReady(invReady), .ackValid(ackValid), .ackAddr(ackAddr),
    .barrierReq(barrierReq), .barrierDone(barrierDone),
    .stateWrEn(stateWrEn), .stateWrAddr(stateWrAddr),
    .fillValid(fillValid), .fillAddr(fillAddr),
    .loadValid(loadValid), .loadAddr(loadAddr), .loadReadReq(loadReadReq)
  );

  always #2 clk = ~clk;  // 250 MHz

  int    checks = 0, fails = 0, cycles = 0;
  bit    finished = 0;
  string reqTag = "R1";

  // reference model state
  int       q[$];
  bit [15:0] lineV = '0;
  bit       mDrain = 0, mAck = 0, mDone = 0;
  int       mAckAddr = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", reqTag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (!rstN) begin
      q.delete(); lineV = '0; mDrain = 0; mAck = 0; mDone = 0; mAckAddr = 0;
    end else begin
      int  sz;
      bit  eReady, ePop, eLoad, acc, dup, push, nDone;
      int  head;
      sz     = q.size();
      eReady = (sz < 4);
      ePop   = mDrain && (sz > 0);
      head   = (sz > 0) ? q[0] : 0;
      eLoad  = loadValid && !lineV[loadAddr];
      chk(invReady == eReady, "invReady", invReady, eReady);
      chk(ackValid == mAck, "ackValid", ackValid, mAck);
      if (mAck) chk(int'(ackAddr) == mAckAddr, "ackAddr", ackAddr, mAckAddr);
      chk(stateWrEn == ePop, "stateWrEn", stateWrEn, ePop);
      if (ePop) chk(int'(stateWrAddr) == head, "stateWrAddr", stateWrAddr, head);
      chk(barrierDone == mDone, "barrierDone", barrierDone, mDone);
      chk(loadReadReq == eLoad, "loadReadReq", loadReadReq, eLoad);
      // advance to the coming rising edge
      acc = invValid && eReady;
      dup = 0;
      for (int k = (ePop ? 1 : 0); k < sz; k++) if (q[k] == int'(invAddr)) dup = 1;
      push = acc && !dup;
      if (fillValid) lineV[fillAddr] = 1'b1;
      if (ePop) begin
        lineV[head] = 1'b0;
        void'(q.pop_front());
      end
      if (push) q.push_back(int'(invAddr));
      nDone = mDrain && (sz == 0) && !push;
      if (nDone) mDrain = 0;
      else if (!mDrain && barrierReq) mDrain = 1;
      mDone    = nDone;
      mAck     = acc;
      mAckAddr = int'(invAddr);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic sendInv(input int a);
    invValid = 1'b1; invAddr = 4'(a); tick(); invValid = 1'b0;
  endtask

  task automatic doLoad(input int a);
    loadValid = 1'b1; loadAddr = 4'(a); tick(); loadValid = 1'b0;
  endtask

  task automatic fillAll();
    for (int a = 0; a < 16; a++) begin
      fillValid = 1'b1; fillAddr = 4'(a); tick();
    end
    fillValid = 1'b0;
  endtask

  task automatic waitDone();
    for (int k = 0; k < 40 && !barrierDone; k++) tick();
    tick();
  endtask

  task automatic barrier();
    barrierReq = 1'b1; tick(); barrierReq = 1'b0; waitDone();
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    reqTag = "R1";
    for (int a = 0; a < 4; a++) doLoad(a);
    reqTag = "R9";
    fillAll();
    for (int a = 0; a < 16; a++) doLoad(a);
    reqTag = "R2";
    sendInv(3); sendInv(5); tick();
    doLoad(3); doLoad(5);
    reqTag = "R3";
    sendInv(7); sendInv(9); sendInv(11);
    invValid = 1'b1; invAddr = 4'd12; tick(); tick(); invValid = 1'b0;
    reqTag = "R5";
    barrier();
    reqTag = "R7";
    doLoad(3); doLoad(5); doLoad(7); doLoad(9); doLoad(11); doLoad(0);
    reqTag = "R4";
    fillAll();
    sendInv(2); sendInv(4); sendInv(2); sendInv(6); sendInv(8); sendInv(10);
    barrier();
    doLoad(2); doLoad(8); doLoad(10);
    reqTag = "R8";
    fillAll();
    sendInv(1); sendInv(13);
    barrierReq = 1'b1; invValid = 1'b1; invAddr = 4'd14; tick();
    barrierReq = 1'b0; invAddr = 4'd1; tick();
    invAddr = 4'd15; tick();
    invValid = 1'b0;
    waitDone();
    doLoad(1); doLoad(13); doLoad(14); doLoad(15);
    reqTag = "R10";
    fillAll();
    sendInv(2); sendInv(4);
    barrierReq = 1'b1; tick(); tick(); tick(); barrierReq = 1'b0;
    waitDone();
    repeat (4) tick();
    reqTag = "R9";
    fillAll();
    sendInv(6);
    barrierReq = 1'b1; tick(); barrierReq = 1'b0;
    fillValid = 1'b1; fillAddr = 4'd6; tick(); fillValid = 1'b0;
    waitDone();
    doLoad(6);
    reqTag = "R6";
    barrier();
    repeat (3) tick();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule